// File: doc/BRIEF.md
# Shared Event Register with Blocking Wait

This block holds one 32-bit event word that four processor cores share for synchronisation. The lower 24 bits are software flags. Any core can raise them with a set request or drop them with a clear request, and the requests of all cores in one cycle are merged. The upper 8 bits are not storage. They mirror eight level flags that the surrounding FIFO logic supplies, so a core can wait on FIFO fill state with the same mechanism it uses for software flags.

Each core owns a private sensitivity mask that it can only write. A core issues a wait by holding its wait request high. While none of the event bits selected by its mask is set, the block holds that core's stall output high. Once a selected bit is present, the stall drops and the core's result output carries the whole event word, including bits outside the mask. The FIFOs and the cores themselves sit outside this block.

Top module: `shared_event_sync`

## Requirements
- R1: Bits 31:24 of every core's wait result equal the `fifoFlags` input in the same cycle. The result holds no registered copy of these bits.
- R2: On a clock edge, a bit k in 23:0 becomes 1 if any core has `setEn` high with bit k of its `setData` at 1, and no clear request for bit k is active in that cycle.
- R3: On a clock edge, a bit k in 23:0 becomes 0 if any core has `clrEn` high with bit k of its `clrData` at 1.
- R4: Set requests from several cores in one cycle are ORed together, and so are their clear requests. A clear of a bit overrides a set of the same bit in that cycle.
- R5: Bits 31:24 of set or clear data have no effect. The top byte keeps following `fifoFlags`, and the lower bits change only as R2 to R4 describe.
- R6: When `maskWrEn[c]` is high, core c's mask is loaded with the full 32-bit `maskWrData` slice c. The new mask applies from the next cycle, and the masks of the other cores do not change.
- R7: `waitStall[c]` is 1 exactly when `waitReq[c]` is 1 and (mask c AND event word) is zero. A wait whose condition already holds when it is issued does not stall.
- R8: A waiting core is released in the cycle after the clock edge that sets one of its selected bits. Several cores can be released in the same cycle.
- R9: `waitResult` slice c carries the full unmasked 32-bit event word for every core c.
- R10: Reset clears bits 23:0 and every core's mask. After reset, any wait stalls until a mask is written.
- R11: Bits 23:0 that no set or clear request targets keep their value across a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifoFlags | input | 8 | FIFO level flags shown as event bits 31:24 |
| maskWrEn | input | 4 | Per-core mask write strobe |
| maskWrData | input | 128 | Per-core new mask, core c in bits 32c+31:32c |
| setEn | input | 4 | Per-core set request |
| setData | input | 128 | Per-core set pattern, core c in bits 32c+31:32c |
| clrEn | input | 4 | Per-core clear request |
| clrData | input | 128 | Per-core clear pattern, core c in bits 32c+31:32c |
| waitReq | input | 4 | Per-core wait request, held while waiting |
| waitStall | output | 4 | Per-core stall, high while the wait is unsatisfied |
| waitResult | output | 128 | Per-core full event word, core c in bits 32c+31:32c |

## Verification
The set and clear paths are driven with several patterns:
- Single-core sets.
- Sets from two cores in one cycle, to show ORing.
- A set and a clear of the same bit from different cores, to show clear priority.
- Patterns that carry ones in the top byte, to show those bits are dropped.

Waits are driven with several cases that tell apart a correct immediate release, an off-by-one-cycle release and a missing simultaneous release:
- A wait issued already satisfied.
- Two cores released by one set.
- A core released only by a change of the FIFO flags.
- A mask written in the same cycle as a wait.

A cycle-by-cycle reference model compares every core's stall and result across the whole run.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_CORES = 4;
  localparam int EVT_W     = 32;
  localparam int HW_W      = 8;
  localparam int SW_W      = EVT_W - HW_W;

  // strobes passed from control to datapath
  typedef struct packed {
    logic [SW_W-1:0]      setBits;
    logic [SW_W-1:0]      clrBits;
    logic [NUM_CORES-1:0] maskLoad;
  } evtStrobe_t;
endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
(
  input  logic [NUM_CORES-1:0]       setEn,
  input  logic [NUM_CORES*EVT_W-1:0] setData,
  input  logic [NUM_CORES-1:0]       clrEn,
  input  logic [NUM_CORES*EVT_W-1:0] clrData,
  input  logic [NUM_CORES-1:0]       maskWrEn,
  input  logic [NUM_CORES-1:0]       waitReq,
  input  logic [NUM_CORES-1:0]       maskHit,
  output evtStrobe_t                 strobe,
  output logic [NUM_CORES-1:0]       waitStall
);
  logic [SW_W-1:0] setAcc;
  logic [SW_W-1:0] clrAcc;

  // merge requests of all cores; top byte of each pattern is dropped (R5)
  always_comb begin
    setAcc = '0;
    clrAcc = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (setEn[c]) setAcc = setAcc | setData[c*EVT_W +: SW_W];
      if (clrEn[c]) clrAcc = clrAcc | clrData[c*EVT_W +: SW_W];
    end
  end

  always_comb begin
    strobe.setBits  = setAcc;
    strobe.clrBits  = clrAcc;
    strobe.maskLoad = maskWrEn;
  end

  // a core stalls while it waits with no selected event present
  always_comb waitStall = waitReq & ~maskHit;
endmodule

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  evtStrobe_t                 strobe,
  input  logic [NUM_CORES*EVT_W-1:0] maskWrData,
  input  logic [HW_W-1:0]            fifoFlags,
  output logic [EVT_W-1:0]           eventVal,
  output logic [NUM_CORES-1:0]       maskHit
);
  logic [SW_W-1:0] swBits;

  // clear wins over set in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) swBits <= '0;
    else        swBits <= (swBits | strobe.setBits) & ~strobe.clrBits;
  end

  always_comb eventVal = {fifoFlags, swBits};

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic [EVT_W-1:0] maskReg;
    always_ff @(posedge clk) begin
      if (!rst_n)                 maskReg <= '0;
      else if (strobe.maskLoad[g]) maskReg <= maskWrData[g*EVT_W +: EVT_W];
    end
    always_comb maskHit[g] = |(maskReg & eventVal);
  end
endmodule

// File: rtl/shared_event_sync.sv
module shared_event_sync
  import evt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [HW_W-1:0]            fifoFlags,
  input  logic [NUM_CORES-1:0]       maskWrEn,
  input  logic [NUM_CORES*EVT_W-1:0] maskWrData,
  input  logic [NUM_CORES-1:0]       setEn,
  input  logic [NUM_CORES*EVT_W-1:0] setData,
  input  logic [NUM_CORES-1:0]       clrEn,
  input  logic [NUM_CORES*EVT_W-1:0] clrData,
  input  logic [NUM_CORES-1:0]       waitReq,
  output logic [NUM_CORES-1:0]       waitStall,
  output logic [NUM_CORES*EVT_W-1:0] waitResult
);
  evtStrobe_t             strobe;
  logic [EVT_W-1:0]       eventVal;
  logic [NUM_CORES-1:0]   maskHit;

  evt_ctrl i_ctrl (
    .setEn(setEn), .setData(setData), .clrEn(clrEn), .clrData(clrData),
    .maskWrEn(maskWrEn), .waitReq(waitReq), .maskHit(maskHit),
    .strobe(strobe), .waitStall(waitStall)
  );

  evt_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .maskWrData(maskWrData),
    .fifoFlags(fifoFlags), .eventVal(eventVal), .maskHit(maskHit)
  );

  always_comb waitResult = {NUM_CORES{eventVal}};
endmodule

// File: rtl/shared_event_sync_chk.sv
module shared_event_sync_chk
  import evt_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic [HW_W-1:0]            fifoFlags,
  input logic [NUM_CORES-1:0]       maskWrEn,
  input logic [NUM_CORES*EVT_W-1:0] maskWrData,
  input logic [NUM_CORES-1:0]       setEn,
  input logic [NUM_CORES*EVT_W-1:0] setData,
  input logic [NUM_CORES-1:0]       clrEn,
  input logic [NUM_CORES*EVT_W-1:0] clrData,
  input logic [NUM_CORES-1:0]       waitReq,
  input logic [NUM_CORES-1:0]       waitStall,
  input logic [NUM_CORES*EVT_W-1:0] waitResult
);
  logic [SW_W-1:0]  setAgg, clrAgg;
  logic [EVT_W-1:0] res0;

  always_comb begin
    setAgg = '0;
    clrAgg = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (setEn[c]) setAgg = setAgg | setData[c*EVT_W +: SW_W];
      if (clrEn[c]) clrAgg = clrAgg | clrData[c*EVT_W +: SW_W];
    end
    res0 = waitResult[EVT_W-1:0];
  end

  // R1
  hw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res0[EVT_W-1:SW_W] == fifoFlags);

  // R2
  set_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((setAgg & ~clrAgg) != '0) |=>
    ((res0[SW_W-1:0] & $past(setAgg & ~clrAgg)) == $past(setAgg & ~clrAgg)));

  // R3
  clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrAgg != '0) |=> ((res0[SW_W-1:0] & $past(clrAgg)) == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setAgg == '0 && clrAgg == '0) |=> (res0[SW_W-1:0] == $past(res0[SW_W-1:0])));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    logic [EVT_W-1:0] shadowMask;
    always_ff @(posedge clk) begin
      if (!rst_n)          shadowMask <= '0;
      else if (maskWrEn[g]) shadowMask <= maskWrData[g*EVT_W +: EVT_W];
    end

    // R7
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waitStall[g] |-> waitReq[g]);

    // R7
    wait_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waitReq[g] |-> (waitStall[g] == ((shadowMask & res0) == '0)));

    // R9
    result_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waitResult[g*EVT_W +: EVT_W] == res0);
  end
endmodule

bind shared_event_sync shared_event_sync_chk i_chk (.*);

// File: tb/test_shared_event_sync.sv
`timescale 1ns/1ps
module test_shared_event_sync;
  import evt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW_W-1:0]            fifoFlags = '0;
  logic [NUM_CORES-1:0]       maskWrEn = '0, setEn = '0, clrEn = '0, waitReq = '0;
  logic [NUM_CORES*EVT_W-1:0] maskWrData = '0, setData = '0, clrData = '0;
  logic [NUM_CORES-1:0]       waitStall;
  logic [NUM_CORES*EVT_W-1:0] waitResult;

  always #2.5 clk = ~clk;

  shared_event_sync i_shared_event_sync (.*);

  typedef struct {
    string            tag;
    int               core;
    logic             expStall;
    logic [EVT_W-1:0] expRes;
  } item_t;

  item_t q[$];
  event  sampleEv;
  int    nChecks = 0, nFails = 0;
  bit    finished = 0;

  logic [SW_W-1:0]  refSw = '0;
  logic [EVT_W-1:0] refMask [NUM_CORES];

  // monitor: compares the design against the expected items
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        nChecks++;
        if (waitStall[it.core] !== it.expStall ||
            waitResult[it.core*EVT_W +: EVT_W] !== it.expRes) begin
          nFails++;
          $display("FAIL %s core%0d: stall=%b result=%h expected stall=%b result=%h",
                   it.tag, it.core, waitStall[it.core],
                   waitResult[it.core*EVT_W +: EVT_W], it.expStall, it.expRes);
        end
      end
    end
  end

  task automatic check(string tag, logic [EVT_W-1:0] act, logic [EVT_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: push the model's expectation for every core (R7, R9)
  task automatic evalCycle(string tag);
    #1;
    for (int c = 0; c < NUM_CORES; c++) begin
      item_t it;
      logic [EVT_W-1:0] ev;
      ev = {fifoFlags, refSw};
      it.tag = tag;
      it.core = c;
      it.expRes = ev;
      it.expStall = waitReq[c] && ((refMask[c] & ev) == '0);
      q.push_back(it);
    end
    -> sampleEv;
    #1;
  endtask

  task automatic tick();
    logic [SW_W-1:0] s, k;
    @(posedge clk);
    s = '0;
    k = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (setEn[c]) s = s | setData[c*EVT_W +: SW_W];
      if (clrEn[c]) k = k | clrData[c*EVT_W +: SW_W];
      if (maskWrEn[c]) refMask[c] = maskWrData[c*EVT_W +: EVT_W];
    end
    if (!rst_n) begin
      refSw = '0;
      for (int c = 0; c < NUM_CORES; c++) refMask[c] = '0;
    end else begin
      refSw = (refSw | s) & ~k;
    end
    @(negedge clk);
    setEn = '0; clrEn = '0; maskWrEn = '0;
    setData = '0; clrData = '0; maskWrData = '0;
  endtask

  task automatic doSet(int c, logic [EVT_W-1:0] v);
    setEn[c] = 1'b1; setData[c*EVT_W +: EVT_W] = v;
  endtask
  task automatic doClr(int c, logic [EVT_W-1:0] v);
    clrEn[c] = 1'b1; clrData[c*EVT_W +: EVT_W] = v;
  endtask
  task automatic doMask(int c, logic [EVT_W-1:0] v);
    maskWrEn[c] = 1'b1; maskWrData[c*EVT_W +: EVT_W] = v;
  endtask

  function automatic logic [EVT_W-1:0] res0();
    return waitResult[EVT_W-1:0];
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    for (int c = 0; c < NUM_CORES; c++) refMask[c] = '0;
    fifoFlags = 8'h25;
    @(negedge clk);
    tick(); tick(); tick();
    rst_n = 1'b1;

    // R10: reset state
    waitReq = 4'hF;
    evalCycle("R10 reset");
    check("R10 reset value", res0(), 32'h25000000);
    check("R10 masks cleared stall", {28'h0, waitStall}, 32'hF);
    tick();

    // R2, R4: sets from two cores ORed
    doSet(0, 32'h00000011); doSet(2, 32'h00000300);
    evalCycle("R2 set issue");
    tick();
    doSet(1, 32'hFF000004);
    evalCycle("R2 set");
    check("R2 R4 ORed set", res0(), 32'h25000311);
    tick();

    // R5: upper set bits ignored; R4: clear beats set of the same bit
    doClr(1, 32'h00000001); doSet(3, 32'h00000001);
    evalCycle("R5 set top");
    check("R5 top byte ignored on set", res0(), 32'h25000315);
    tick();
    doClr(0, 32'hFF000010);
    evalCycle("R4 override");
    check("R4 clear overrides set", res0(), 32'h25000314);

    // R6: masks written now apply next cycle; core2 stops waiting
    tick();
    doMask(0, 32'h00000800); doMask(1, 32'h00000800);
    doMask(2, 32'h00000004); doMask(3, 32'h80000000);
    waitReq = 4'b1011;
    evalCycle("R3 clear");
    check("R3 R5 clear with top bits", res0(), 32'h25000304);
    check("R6 mask not yet active", {28'h0, waitStall}, 32'hB);
    tick();

    // R7: core2 wait already satisfied on issue
    waitReq = 4'hF;
    doSet(2, 32'h00000800);
    evalCycle("R7 immediate");
    check("R7 immediate release", {28'h0, waitStall}, 32'hB);
    tick();

    // R8: cores 0 and 1 released together; R9 full word
    evalCycle("R8 release");
    check("R8 simultaneous release", {28'h0, waitStall}, 32'h8);
    check("R9 unmasked result core1", waitResult[EVT_W +: EVT_W], 32'h25000B04);
    tick();

    // R1: FIFO flag change releases core3 combinationally
    fifoFlags = 8'hA5;
    evalCycle("R1 fifo");
    check("R1 fifo flags release", {28'h0, waitStall}, 32'h0);
    check("R1 top byte follows", res0(), 32'hA5000B04);
    tick();

    // R11: hold across idle cycles
    for (int n = 0; n < 3; n++) begin
      evalCycle("R11 idle");
      tick();
    end
    evalCycle("R11 idle");
    check("R11 hold", res0(), 32'hA5000B04);

    // R6: mask private per core
    doMask(3, 32'h00000000);
    tick();
    evalCycle("R6 private");
    check("R6 private mask", {28'h0, waitStall}, 32'h8);
    tick();

    // R7: no request, no stall
    waitReq = 4'h0;
    evalCycle("R7 no request");
    check("R7 idle no stall", {28'h0, waitStall}, 32'h0);
    tick();

    summary();
  end
endmodule